// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns a single operation request into the sequence of command, address and data cycles on an 8-bit asynchronous NAND flash bus for large-page devices. A request carries an operation code, a bank number, a page (row) address and a flag that limits a read or program to the spare area. The block then runs the whole sequence on its own. It raises the chip enable of the addressed bank, marks command cycles with CLE and address cycles with ALE, and pulses WE# or RE# for each byte. Data moves through byte-wide streaming ports toward a buffer. When the sequence ends, the block raises a one-cycle `done`, together with `error` if it aborted.

The controller is a single state machine. Its states are IDLE, CMD (first command byte), ADDR (address bytes), CONFIRM (second command byte), BUSY_WAIT (wait for the bank's ready/busy line), STAT_CMD (status command), STAT_READ (status byte read, repeated), REARM (return to read mode), XFER (page data), ID_READ (identifier bytes), FINISH (normal end) and FAIL (abort). The transitions are as follows:
- IDLE goes to CMD, to STAT_CMD or to FAIL when a request is accepted.
- CMD goes to ADDR, or to BUSY_WAIT for a reset.
- ADDR goes to CONFIRM, XFER or ID_READ once its last address byte is sent.
- CONFIRM goes to STAT_CMD, and STAT_CMD goes to STAT_READ.
- STAT_READ stays in place until the ready bit is seen, then goes to REARM. It goes to FAIL when the retry limit is spent.
- REARM goes to XFER for a read and to FINISH otherwise.
- XFER goes to FINISH for a read and to CONFIRM for a program.
- ID_READ goes to FINISH, and BUSY_WAIT goes to FINISH or FAIL.
- FINISH and FAIL both return to IDLE.

A shared strobe timer produces every WE#/RE# pulse. Its width comes from a 4-bit field per bank. A small address generator supplies the address bytes.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset every chip enable, WE# and RE# is high, CLE, ALE, `done` and `error` are low, and `req_ready` is high.
- R2: While an operation runs, only the chip enable of the requested bank is low. All chip enables are high in IDLE, FINISH and FAIL, including after an abort.
- R3: Each WE# or RE# low pulse lasts W clock cycles and is followed by at least W high cycles. W is the bank's 4-bit field in `strobe_cfg` (bits [4b+3:4b] for bank b), and a field of 0 gives W=1. CLE and ALE are never high together, and WE# and RE# are never low together.
- R4: Op code 0 (read) writes command 0x00, then five address bytes, then command 0x30, then runs the status wait, then reads the data. The address bytes are column low, column high, then page bits [7:0], [15:8] and [23:16]. The column is 0, or DATA_BYTES (0x800 by default) when `req_spare_only` is set. The read moves DATA_BYTES+SPARE_BYTES bytes, or only SPARE_BYTES when `req_spare_only` is set.
- R5: Op code 1 (program) writes command 0x80, then the same five address bytes, then the data bytes taken from `wr_data`, then command 0x10, then runs the status wait. The byte count follows the rule of R4. `wr_pop` pulses once as each byte's cycle ends.
- R6: Op code 2 (erase) writes command 0x60, then three address bytes (page [7:0], [15:8], [23:16]), then command 0xD0, then runs the status wait.
- R7: The status wait writes command 0x70 once and then repeats status byte reads until bit 6 of the byte is 1. All other bits are ignored. It then writes command 0x00. Op code 5 runs the status wait alone.
- R8: If POLL_LIMIT status reads all show bit 6 clear, the operation ends with `error`. In that case command 0x00 is not written.
- R9: Op code 3 (reset) writes command 0xFF, then waits until the bank's `nand_rb` bit is high. It then ends with `fifo_flush` high in the same cycle as `done`.
- R10: If the ready/busy line stays low for RB_TIMEOUT cycles, the operation ends with `error` and all strobes are released.
- R11: Op code 4 (ID read) writes command 0x90 and one address byte 0x00, then reads four bytes. The first byte read lands in `id_word[7:0]` and the fourth in `id_word[31:24]`. `id_word` is valid when `done` is high.
- R12: `done` is a one-cycle pulse, and `error` is high only together with `done`. Op codes 6 and 7 end at once with `error` and produce no bus cycle.
- R13: In a read, each data byte appears on `rd_data` with a one-cycle `rd_valid` pulse, in the order the bytes are read from the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_op | input | 3 | Operation code (0 read, 1 program, 2 erase, 3 reset, 4 ID, 5 status) |
| req_bank | input | 2 | Target bank |
| req_page | input | 24 | Page (row) address |
| req_spare_only | input | 1 | Limit a read or program to the spare area |
| strobe_cfg | input | 16 | Per-bank 4-bit strobe width fields |
| req_ready | output | 1 | Sequencer idle |
| done | output | 1 | Operation finished (one cycle) |
| error | output | 1 | Operation aborted (with `done`) |
| id_word | output | 32 | Identifier bytes from the last ID read |
| fifo_flush | output | 1 | Buffer flush request at the end of a reset |
| wr_data | input | 8 | Next byte to program, shown ahead of `wr_pop` |
| wr_pop | output | 1 | Current program byte consumed |
| rd_data | output | 8 | Byte read from the page |
| rd_valid | output | 1 | `rd_data` valid |
| nand_ce_n | output | 4 | Per-bank chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus byte driven out |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Bus byte driven by the device |
| nand_rb | input | 4 | Per-bank ready/busy, high when ready |

## Verification
The outputs of an operation are due at different times. `done` and `error` come on the cycle after the last strobe's high phase, or on the cycle after an abort condition. An invalid op code gives `done` on the first cycle after the request is accepted. `rd_valid` comes one cycle after the last low cycle of each RE# pulse, and `id_word` is stable by `done`. The bench acts as the device: it logs every byte on the rising edge of WE#, and it sets the read byte on the falling edge of RE#. A monitor samples at each falling clock edge, away from the active edge, and checks the low-pulse lengths, the chip enables and the read bytes on every cycle. The logged byte sequence, the flags and `id_word` are compared with a model built from the requirements once `done` has been seen.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_RESET  = 3'd3,
        OP_ID     = 3'd4,
        OP_STATUS = 3'd5
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_CONFIRM,
        ST_BUSY_WAIT,
        ST_STAT_CMD,
        ST_STAT_READ,
        ST_REARM,
        ST_XFER,
        ST_ID_READ,
        ST_FINISH,
        ST_FAIL
    } st_e;

    localparam logic [7:0] CMD_RD_SETUP = 8'h00;
    localparam logic [7:0] CMD_RD_GO    = 8'h30;
    localparam logic [7:0] CMD_PG_SETUP = 8'h80;
    localparam logic [7:0] CMD_PG_GO    = 8'h10;
    localparam logic [7:0] CMD_ER_SETUP = 8'h60;
    localparam logic [7:0] CMD_ER_GO    = 8'hD0;
    localparam logic [7:0] CMD_STATUS   = 8'h70;
    localparam logic [7:0] CMD_ID       = 8'h90;
    localparam logic [7:0] CMD_RESET    = 8'hFF;

    localparam int STAT_READY_BIT = 6;

    function automatic logic [7:0] setup_cmd(input logic [2:0] op);
        case (op)
            OP_PROG:  return CMD_PG_SETUP;
            OP_ERASE: return CMD_ER_SETUP;
            OP_RESET: return CMD_RESET;
            OP_ID:    return CMD_ID;
            default:  return CMD_RD_SETUP;
        endcase
    endfunction

    function automatic logic [7:0] confirm_cmd(input logic [2:0] op);
        case (op)
            OP_PROG:  return CMD_PG_GO;
            OP_ERASE: return CMD_ER_GO;
            default:  return CMD_RD_GO;
        endcase
    endfunction

endpackage

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd_sel,
    input  logic [TW-1:0] width,
    output logic          we_low,
    output logic          re_low,
    output logic          sample,
    output logic          done
);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_e;

    localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

    ph_e           ph;
    logic [TW-1:0] cnt;
    logic          rd_q;
    logic [TW-1:0] w_eff;

    assign w_eff = (width == '0) ? ONE : width;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            rd_q <= 1'b0;
        end else begin
            unique case (ph)
                PH_IDLE: if (start) begin
                    ph   <= PH_LOW;
                    cnt  <= w_eff - ONE;
                    rd_q <= rd_sel;
                end
                PH_LOW: if (cnt == '0) begin
                    ph  <= PH_HIGH;
                    cnt <= w_eff - ONE;
                end else begin
                    cnt <= cnt - ONE;
                end
                PH_HIGH: if (cnt == '0) ph <= PH_IDLE;
                         else           cnt <= cnt - ONE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign we_low = (ph == PH_LOW) && !rd_q;
    assign re_low = (ph == PH_LOW) &&  rd_q;
    assign sample = (ph == PH_LOW)  && (cnt == '0);
    assign done   = (ph == PH_HIGH) && (cnt == '0);

    // R3
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ph == PH_IDLE);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != PH_IDLE) |-> cnt < w_eff);

endmodule

// File: rtl/nand_addr_gen.sv
module nand_addr_gen
    import nand_seq_pkg::*;
#(
    parameter int ROW_W     = 24,
    parameter int COL_SPARE = 2048
) (
    input  logic [2:0]       op,
    input  logic [2:0]       idx,
    input  logic [ROW_W-1:0] page,
    input  logic             spare_only,
    output logic [7:0]       abyte,
    output logic [2:0]       acount
);

    logic [15:0] col;
    logic [23:0] row;

    assign col = spare_only ? 16'(COL_SPARE) : 16'h0000;
    assign row = 24'(page);

    always_comb begin
        abyte  = 8'h00;
        acount = 3'd1;
        if (op == OP_READ || op == OP_PROG) begin
            acount = 3'd5;
            case (idx)
                3'd0:    abyte = col[7:0];
                3'd1:    abyte = col[15:8];
                3'd2:    abyte = row[7:0];
                3'd3:    abyte = row[15:8];
                default: abyte = row[23:16];
            endcase
        end else if (op == OP_ERASE) begin
            acount = 3'd3;
            case (idx)
                3'd0:    abyte = row[7:0];
                3'd1:    abyte = row[15:8];
                default: abyte = row[23:16];
            endcase
        end
    end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int BANKS       = 4,
    parameter int ROW_W       = 24,
    parameter int TW          = 4,
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int POLL_LIMIT  = 16384,
    parameter int RB_TIMEOUT  = 262144
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [2:0]            req_op,
    input  logic [1:0]            req_bank,
    input  logic [ROW_W-1:0]      req_page,
    input  logic                  req_spare_only,
    input  logic [BANKS*TW-1:0]   strobe_cfg,
    output logic                  req_ready,
    output logic                  done,
    output logic                  error,
    output logic [31:0]           id_word,
    output logic                  fifo_flush,
    input  logic [7:0]            wr_data,
    output logic                  wr_pop,
    output logic [7:0]            rd_data,
    output logic                  rd_valid,
    output logic [BANKS-1:0]      nand_ce_n,
    output logic                  nand_cle,
    output logic                  nand_ale,
    output logic                  nand_we_n,
    output logic                  nand_re_n,
    output logic [7:0]            nand_dq_out,
    output logic                  nand_dq_oe,
    input  logic [7:0]            nand_dq_in,
    input  logic [BANKS-1:0]      nand_rb
);

    localparam int CW  = $clog2(DATA_BYTES + SPARE_BYTES + 1);
    localparam int PW  = $clog2(POLL_LIMIT + 1);
    localparam int TOW = $clog2(RB_TIMEOUT + 1);
    localparam logic [CW-1:0] LEN_FULL  = CW'(DATA_BYTES + SPARE_BYTES);
    localparam logic [CW-1:0] LEN_SPARE = CW'(SPARE_BYTES);

    st_e              state, state_nx;
    logic [2:0]       op_q;
    logic [1:0]       bank_q;
    logic [ROW_W-1:0] page_q;
    logic             spare_q;
    logic [TW-1:0]    width_q;
    logic             launched;
    logic [CW-1:0]    idx;
    logic [PW-1:0]    poll_cnt;
    logic [TOW-1:0]   tmo_cnt;
    logic             stat_rdy;
    logic [31:0]      id_q;
    logic [7:0]       rd_q;
    logic             rd_v;

    logic             bus_state, tmr_start, tmr_rd, tmr_sample, tmr_done;
    logic             we_low, re_low;
    logic [7:0]       abyte;
    logic [2:0]       acount;
    logic [CW-1:0]    xfer_len;

    assign xfer_len  = spare_q ? LEN_SPARE : LEN_FULL;
    assign bus_state = state inside {ST_CMD, ST_ADDR, ST_CONFIRM, ST_STAT_CMD,
                                     ST_STAT_READ, ST_REARM, ST_XFER, ST_ID_READ};
    assign tmr_start = bus_state && !launched;
    assign tmr_rd    = (state == ST_STAT_READ) || (state == ST_ID_READ) ||
                       (state == ST_XFER && op_q == OP_READ);

    nand_strobe_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .rd_sel (tmr_rd),
        .width  (width_q),
        .we_low (we_low),
        .re_low (re_low),
        .sample (tmr_sample),
        .done   (tmr_done)
    );

    nand_addr_gen #(.ROW_W(ROW_W), .COL_SPARE(DATA_BYTES)) u_addr (
        .op         (op_q),
        .idx        (idx[2:0]),
        .page       (page_q),
        .spare_only (spare_q),
        .abyte      (abyte),
        .acount     (acount)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                if (req_op > OP_STATUS)       state_nx = ST_FAIL;
                else if (req_op == OP_STATUS) state_nx = ST_STAT_CMD;
                else                          state_nx = ST_CMD;
            end
            ST_CMD: if (tmr_done)
                state_nx = (op_q == OP_RESET) ? ST_BUSY_WAIT : ST_ADDR;
            ST_ADDR: if (tmr_done && idx == CW'(acount - 3'd1)) begin
                if (op_q == OP_PROG)    state_nx = ST_XFER;
                else if (op_q == OP_ID) state_nx = ST_ID_READ;
                else                    state_nx = ST_CONFIRM;
            end
            ST_CONFIRM:   if (tmr_done) state_nx = ST_STAT_CMD;
            ST_STAT_CMD:  if (tmr_done) state_nx = ST_STAT_READ;
            ST_STAT_READ: if (tmr_done) begin
                if (stat_rdy)                              state_nx = ST_REARM;
                else if (poll_cnt == PW'(POLL_LIMIT - 1))  state_nx = ST_FAIL;
            end
            ST_REARM: if (tmr_done)
                state_nx = (op_q == OP_READ) ? ST_XFER : ST_FINISH;
            ST_XFER: if (tmr_done && idx == xfer_len - CW'(1))
                state_nx = (op_q == OP_READ) ? ST_FINISH : ST_CONFIRM;
            ST_ID_READ: if (tmr_done && idx == CW'(3)) state_nx = ST_FINISH;
            ST_BUSY_WAIT: begin
                if (nand_rb[bank_q])                       state_nx = ST_FINISH;
                else if (tmo_cnt == TOW'(RB_TIMEOUT - 1))  state_nx = ST_FAIL;
            end
            ST_FINISH: state_nx = ST_IDLE;
            ST_FAIL:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_q     <= 3'd0;
            bank_q   <= 2'd0;
            page_q   <= '0;
            spare_q  <= 1'b0;
            width_q  <= '0;
            launched <= 1'b0;
            idx      <= '0;
            poll_cnt <= '0;
            tmo_cnt  <= '0;
            stat_rdy <= 1'b0;
            id_q     <= '0;
            rd_q     <= '0;
            rd_v     <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_valid) begin
                op_q    <= req_op;
                bank_q  <= req_bank;
                page_q  <= req_page;
                spare_q <= req_spare_only;
                width_q <= strobe_cfg[req_bank*TW +: TW];
                id_q    <= '0;
            end
            if (tmr_start)     launched <= 1'b1;
            else if (tmr_done) launched <= 1'b0;
            if (state_nx != state) idx <= '0;
            else if (tmr_done)     idx <= idx + CW'(1);
            if (state == ST_IDLE)                        poll_cnt <= '0;
            else if (state == ST_STAT_READ && tmr_done)  poll_cnt <= poll_cnt + PW'(1);
            tmo_cnt <= (state == ST_BUSY_WAIT) ? tmo_cnt + TOW'(1) : '0;
            if (tmr_sample) stat_rdy <= nand_dq_in[STAT_READY_BIT];
            if (tmr_sample && state == ST_ID_READ) id_q[idx[1:0]*8 +: 8] <= nand_dq_in;
            rd_v <= tmr_sample && state == ST_XFER && op_q == OP_READ;
            if (tmr_sample && state == ST_XFER) rd_q <= nand_dq_in;
        end
    end

    // outputs
    always_comb begin
        nand_ce_n   = '1;
        nand_cle    = 1'b0;
        nand_ale    = 1'b0;
        nand_dq_out = 8'h00;
        if (bus_state || state == ST_BUSY_WAIT)
            nand_ce_n = ~(BANKS'(1) << bank_q);
        unique case (state)
            ST_CMD:      begin nand_cle = 1'b1; nand_dq_out = setup_cmd(op_q);   end
            ST_CONFIRM:  begin nand_cle = 1'b1; nand_dq_out = confirm_cmd(op_q); end
            ST_STAT_CMD: begin nand_cle = 1'b1; nand_dq_out = CMD_STATUS;        end
            ST_REARM:    begin nand_cle = 1'b1; nand_dq_out = CMD_RD_SETUP;      end
            ST_ADDR:     begin nand_ale = 1'b1; nand_dq_out = abyte;             end
            ST_XFER:     nand_dq_out = (op_q == OP_PROG) ? wr_data : 8'h00;
            default:     nand_dq_out = 8'h00;
        endcase
        nand_dq_oe = nand_cle || nand_ale || (state == ST_XFER && op_q == OP_PROG);
        nand_we_n  = !we_low;
        nand_re_n  = !re_low;
        req_ready  = (state == ST_IDLE);
        done       = (state == ST_FINISH) || (state == ST_FAIL);
        error      = (state == ST_FAIL);
        fifo_flush = (state == ST_FINISH) && (op_q == OP_RESET);
        wr_pop     = (state == ST_XFER) && (op_q == OP_PROG) && tmr_done;
        id_word    = id_q;
        rd_data    = rd_q;
        rd_valid   = rd_v;
    end

    // R3
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R3
    we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R2
    ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nand_ce_n));

    // R2
    done_ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> &nand_ce_n);

    // R12
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13
    rd_valid_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (op_q == OP_READ) && !done);

endmodule

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb;

    localparam int DATA_B  = 32;
    localparam int SPARE_B = 8;
    localparam int PLIM    = 8;
    localparam int RBTO    = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [23:0] req_page = '0;
    logic        req_spare_only = 1'b0;
    logic [15:0] strobe_cfg = {4'd3, 4'd1, 4'd2, 4'd1};
    logic        req_ready, done, error, fifo_flush, wr_pop, rd_valid;
    logic [31:0] id_word;
    logic [7:0]  wr_data, rd_data, dq_out;
    logic [7:0]  dq_in = 8'h00;
    logic [3:0]  ce_n, rb;
    logic        cle, ale, we_n, re_n, dq_oe;

    always #2.5 clk = ~clk;

    nand_cmd_seq #(.DATA_BYTES(DATA_B), .SPARE_BYTES(SPARE_B),
                   .POLL_LIMIT(PLIM), .RB_TIMEOUT(RBTO)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_page(req_page), .req_spare_only(req_spare_only),
        .strobe_cfg(strobe_cfg), .req_ready(req_ready), .done(done), .error(error),
        .id_word(id_word), .fifo_flush(fifo_flush), .wr_data(wr_data), .wr_pop(wr_pop),
        .rd_data(rd_data), .rd_valid(rd_valid), .nand_ce_n(ce_n), .nand_cle(cle),
        .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n), .nand_dq_out(dq_out),
        .nand_dq_oe(dq_oe), .nand_dq_in(dq_in), .nand_rb(rb));

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [9:0] bus_log[$];
    logic [9:0] exp_log[$];
    int dev_mode = 0;         // 0 data, 1 status, 2 id
    int dev_rd = 0;
    int stat_reads = 0;
    int busy_polls = 0;
    bit reset_req = 0;
    bit rb_stuck = 0;
    int rb_cnt = 0;
    logic [7:0] id_b [4] = '{8'h2C, 8'hD3, 8'h51, 8'h95};

    always @(posedge we_n) begin
        bus_log.push_back({cle, ale, dq_out});
        if (cle) begin
            case (dq_out)
                8'h70: begin dev_mode = 1; stat_reads = 0; end
                8'h00: begin dev_mode = 0; dev_rd = 0; end
                8'h90: begin dev_mode = 2; dev_rd = 0; end
                8'hFF: reset_req = 1;
                default: ;
            endcase
        end
    end

    always @(negedge re_n) begin
        if (dev_mode == 1)      dq_in = (stat_reads >= busy_polls) ? 8'h40 : 8'hBF;
        else if (dev_mode == 2) dq_in = id_b[dev_rd % 4];
        else                    dq_in = 8'((dev_rd * 5) + 1);
    end

    always @(posedge re_n) begin
        if (dev_mode == 1) stat_reads++;
        else               dev_rd++;
    end

    always @(negedge clk) begin
        if (reset_req) begin rb_cnt = 10; reset_req = 0; end
        else if (rb_cnt > 0) rb_cnt--;
    end
    assign rb = (rb_stuck || rb_cnt > 0) ? 4'h0 : 4'hF;

    // ---------------- data buffer model ----------------
    int wr_idx = 0;
    assign wr_data = 8'((wr_idx * 3) + 7);

    // ---------------- per-clock monitor ----------------
    int cur_bank = 0;
    int exp_w = 1;
    int we_run = 0, re_run = 0;
    int pw_err = 0, ce_err = 0, rd_err = 0, rd_cnt = 0;
    bit flush_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!we_n) we_run++;
            else if (we_run != 0) begin if (we_run != exp_w) pw_err++; we_run = 0; end
            if (!re_n) re_run++;
            else if (re_run != 0) begin if (re_run != exp_w) pw_err++; re_run = 0; end
            if (ce_n != 4'hF && ce_n != ~(4'b0001 << cur_bank)) ce_err++;
            if ((!we_n || !re_n) && ce_n != ~(4'b0001 << cur_bank)) ce_err++;
            if (rd_valid) begin
                if (rd_data != 8'((rd_cnt * 5) + 1)) rd_err++;
                rd_cnt++;
            end
            if (wr_pop) wr_idx++;
            if (fifo_flush) flush_seen = 1;
        end
    end

    // ---------------- helpers ----------------
    task automatic ec(input logic [7:0] b); exp_log.push_back({2'b10, b}); endtask
    task automatic ea(input logic [7:0] b); exp_log.push_back({2'b01, b}); endtask
    task automatic ed(input logic [7:0] b); exp_log.push_back({2'b00, b}); endtask

    task automatic addr5(input logic [23:0] pg, input bit sp);
        logic [15:0] col = sp ? 16'(DATA_B) : 16'h0;
        ea(col[7:0]); ea(col[15:8]); ea(pg[7:0]); ea(pg[15:8]); ea(pg[23:16]);
    endtask

    task automatic cmp_log(input string req);
        int bad = -1;
        if (bus_log.size() == exp_log.size()) begin
            for (int i = 0; i < exp_log.size(); i++)
                if (bad < 0 && bus_log[i] != exp_log[i]) bad = i;
            if (bad < 0) chk(1'b1, req, 0, 0);
            else chk(1'b0, {req, " bus byte"}, longint'(bus_log[bad]), longint'(exp_log[bad]));
        end else begin
            chk(1'b0, {req, " bus cycle count"}, bus_log.size(), exp_log.size());
        end
    endtask

    logic got_err;

    task automatic do_op(input logic [2:0] op, input logic [1:0] bank,
                         input logic [23:0] page, input bit sp);
        int n = 0;
        logic [3:0] f;
        bus_log.delete(); exp_log.delete();
        rd_cnt = 0; rd_err = 0; pw_err = 0; ce_err = 0; flush_seen = 0; wr_idx = 0;
        cur_bank = bank;
        f = strobe_cfg[bank*4 +: 4];
        exp_w = (f == 0) ? 1 : int'(f);
        @(negedge clk);
        req_valid = 1; req_op = op; req_bank = bank; req_page = page; req_spare_only = sp;
        @(negedge clk);
        req_valid = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        got_err = error;
        if (!done) chk(1'b0, "R12 done never seen", 0, 1);
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R12 actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // ---------------- sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(ce_n == 4'hF && we_n && re_n && !cle && !ale && req_ready && !done && !error,
            "R1 idle outputs", {ce_n, we_n, re_n, cle, ale, req_ready, done, error},
            {4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});

        // R9 reset on bank 1
        do_op(3'd3, 2'd1, 24'h0, 0);
        ec(8'hFF);
        cmp_log("R9 reset command");
        chk(!got_err && flush_seen, "R9 flush and no error", {got_err, flush_seen}, 2'b01);

        // R11 ID read on bank 0
        do_op(3'd4, 2'd0, 24'h0, 0);
        ec(8'h90); ea(8'h00);
        cmp_log("R11 id sequence");
        chk(id_word == 32'h9551D32C, "R11 id word", id_word, 32'h9551D32C);

        // R4 R7 R13 full page read on bank 2, three busy polls
        busy_polls = 3;
        do_op(3'd0, 2'd2, 24'hA1B2C3, 0);
        ec(8'h00); addr5(24'hA1B2C3, 0); ec(8'h30); ec(8'h70); ec(8'h00);
        cmp_log("R4 read sequence");
        chk(stat_reads == 4, "R7 status reads until bit 6", stat_reads, 4);
        chk(rd_cnt == DATA_B + SPARE_B && rd_err == 0, "R13 read bytes",
            {rd_cnt, rd_err}, {DATA_B + SPARE_B, 0});
        chk(pw_err == 0 && ce_err == 0, "R3 R2 strobe width and enables", {pw_err, ce_err}, 0);

        // R4 spare-only read, width 3 on bank 3
        busy_polls = 0;
        do_op(3'd0, 2'd3, 24'h000102, 1);
        ec(8'h00); addr5(24'h000102, 1); ec(8'h30); ec(8'h70); ec(8'h00);
        cmp_log("R4 spare read column");
        chk(rd_cnt == SPARE_B && rd_err == 0 && pw_err == 0, "R4 spare count and width",
            {rd_cnt, rd_err, pw_err}, {SPARE_B, 0, 0});

        // R5 program full page on bank 0
        busy_polls = 2;
        do_op(3'd1, 2'd0, 24'h0F0E0D, 0);
        ec(8'h80); addr5(24'h0F0E0D, 0);
        for (int i = 0; i < DATA_B + SPARE_B; i++) ed(8'((i * 3) + 7));
        ec(8'h10); ec(8'h70); ec(8'h00);
        cmp_log("R5 program sequence");
        chk(wr_idx == DATA_B + SPARE_B && !got_err, "R5 pops", wr_idx, DATA_B + SPARE_B);

        // R6 erase on bank 1 with field 0 (R3 minimum width)
        strobe_cfg[7:4] = 4'd0;
        busy_polls = 1;
        do_op(3'd2, 2'd1, 24'h123456, 0);
        ec(8'h60); ea(8'h56); ea(8'h34); ea(8'h12); ec(8'hD0); ec(8'h70); ec(8'h00);
        cmp_log("R6 erase sequence");
        chk(pw_err == 0 && exp_w == 1, "R3 zero field gives one cycle", pw_err, 0);
        strobe_cfg[7:4] = 4'd2;

        // R7 standalone status wait
        busy_polls = 0;
        do_op(3'd5, 2'd2, 24'h0, 0);
        ec(8'h70); ec(8'h00);
        cmp_log("R7 status op");

        // R8 poll limit exhausted
        busy_polls = 1000;
        do_op(3'd5, 2'd3, 24'h0, 0);
        ec(8'h70);
        cmp_log("R8 no rearm after timeout");
        chk(got_err && stat_reads == PLIM, "R8 error after limit", {got_err, stat_reads}, {1'b1, PLIM});
        busy_polls = 0;

        // R10 ready/busy stuck low
        rb_stuck = 1;
        do_op(3'd3, 2'd2, 24'h0, 0);
        chk(got_err == 1'b1, "R10 timeout error", got_err, 1);
        chk(ce_n == 4'hF && we_n && re_n && !cle && !ale, "R10 R2 strobes released",
            {ce_n, we_n, re_n, cle, ale}, {4'hF, 1'b1, 1'b1, 1'b0, 1'b0});
        rb_stuck = 0;

        // R12 invalid op code
        do_op(3'd7, 2'd0, 24'h0, 0);
        chk(got_err == 1'b1, "R12 invalid op error", got_err, 1);
        chk(bus_log.size() == 0, "R12 invalid op no bus cycle", bus_log.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule